// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of N DMA channels currently owns a shared transfer engine. Each channel presents a request, an enable and a group bit that places it in either the urgent group or the normal group. It also presents a 4-bit run-length code R. A requesting channel in the urgent group always beats every channel in the normal group. Inside a group, the channel with the smaller index wins.

Once a channel holds the grant, it keeps it for a run of 2^R completed transfers. The engine reports each completed transfer with a one-cycle strobe. The grant is released early if the owner's request or enable drops. When the owner is released, arbitration runs again. The grant is held in a register, so a decision made from the inputs of one cycle appears on the outputs after the next clock edge. A one-cycle strobe marks the first cycle of every new grant, and that includes a repeat grant to the same channel.

The transfer engine watches the one-hot grant or the index and moves data for the selected channel. Descriptor handling and data movement belong to the engine, not to this block.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is held low at a clock edge, and in the cycle after, the grant vector is all zeros, the index is 0 and the rearbitration strobe is low.
- R2: A channel whose enable bit is 0 never receives a grant, even while its request is 1. Disabling the owner releases it at the next clock edge.
- R3: When any enabled, requesting channel has its group bit at 1 (urgent group), the grant goes to an urgent-group channel and never to a channel whose group bit is 0.
- R4: Within the winning group, the grant goes to the requesting, enabled channel with the lowest index.
- R5: A granted channel keeps the grant until it has completed 2^R transfers. A transfer is counted on each cycle that the done strobe is high while a grant is held. R is that channel's code, sampled when the grant is made, and codes above 10 act as 10, which caps a run at 1024 transfers. At the clock edge that follows the last transfer of the run, a new arbitration result is loaded.
- R6: If the owner's request drops before its run ends, the grant is re-decided at the next clock edge.
- R7: When no channel is both enabled and requesting, the grant vector is zero, the index is 0, and done strobes have no effect.
- R8: Every new grant starts its transfer count from zero, so a channel that is granted again after an early release receives a full 2^R run.
- R9: The grant vector changes only at a rearbitration point. The rearbitration strobe is high for exactly the first cycle of each new grant, and that includes a repeat grant to the channel that just finished.
- R10: The grant vector is one-hot or zero, and the index output equals the position of its set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | N_CH | Per-channel transfer request |
| en_i | input | N_CH | Per-channel enable |
| hi_pri_i | input | N_CH | Group bit per channel (1 = urgent group) |
| run_code_i | input | N_CH*4 | Run-length code R per channel; channel k occupies bits [4k+3:4k] |
| xfer_done_i | input | 1 | One-cycle strobe for each completed transfer |
| grant_o | output | N_CH | One-hot grant, zero when idle |
| grant_idx_o | output | IDX_W | Index of the granted channel, 0 when idle |
| rearb_o | output | 1 | High in the first cycle of each new grant |

## Verification
Directed patterns each target one question:
- Mixed urgent and normal requests check that group rank overrides index, and a pair of same-group requesters checks that the lower index wins.
- A disabled channel that keeps requesting checks that the enable is honoured.
- A run with R=3 has a lower-index channel arrive mid-run. Done counts that stop one short of the run length, and then reach it, show whether the run ends on exactly the right transfer.
- A code of 15 checks the clamp to 1024 transfers.
- An early request drop followed by a regrant shows whether the counter was cleared.

A long random phase then mixes all inputs. A behavioural queue-free model with integer owner and count compares the full output set on every clock.

// File: rtl/dma_arb_pkg.sv
// Package: shared constants and the run-limit helper for the DMA arbiter.
// Assumes run codes are 4 bits wide and runs are capped at 2^10 transfers.
package dma_arb_pkg;

    localparam int RCODE_W   = 4;
    localparam int MAX_SHIFT = 10;
    localparam int CNT_W     = MAX_SHIFT;

    // Turn a run code into (2^R - 1), clamping R at MAX_SHIFT.
    function automatic logic [CNT_W-1:0] run_last_count(input logic [RCODE_W-1:0] code);
        logic [RCODE_W-1:0] eff;
        logic [CNT_W:0]     full;
        eff  = (code > RCODE_W'(MAX_SHIFT)) ? RCODE_W'(MAX_SHIFT) : code;
        full = ({{CNT_W{1'b0}}, 1'b1} << eff) - 1'b1;
        return full[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/dma_arb_lowest.sv
// Finds the lowest-indexed set bit of a vector.
// Assumes IDX_W is wide enough to hold N_CH-1. idx_o is 0 when no bit is set.
module dma_arb_lowest #(
    parameter int N_CH  = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_CH-1:0]  vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Downward scan so the smallest set index is the last one written.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_arb_pick.sv
// Two-group fixed-priority picker. The urgent group ranks above the normal
// group, and inside a group the lower index wins.
// Assumes elig_i already combines request and enable.
module dma_arb_pick #(
    parameter int N_CH  = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_CH-1:0]  elig_i,
    input  logic [N_CH-1:0]  hi_i,
    output logic             found_o,
    output logic [IDX_W-1:0] win_o
);

    logic [N_CH-1:0]  grp_vec   [2];
    logic             grp_found [2];
    logic [IDX_W-1:0] grp_idx   [2];

    // Group 1 holds the urgent channels and group 0 the normal ones.
    always_comb begin
        grp_vec[1] = elig_i & hi_i;
        grp_vec[0] = elig_i & ~hi_i;
    end

    for (genvar g = 0; g < 2; g++) begin : g_grp
        dma_arb_lowest #(.N_CH(N_CH), .IDX_W(IDX_W)) u_low (
            .vec_i   (grp_vec[g]),
            .found_o (grp_found[g]),
            .idx_o   (grp_idx[g])
        );
    end

    // Any urgent candidate overrides every normal candidate.
    always_comb begin
        found_o = grp_found[1] | grp_found[0];
        win_o   = grp_found[1] ? grp_idx[1] : grp_idx[0];
    end

endmodule

// File: rtl/dma_arb_run_cnt.sv
// Run-length counter. It loads the winner's limit when a grant is made and
// counts completed transfers while a grant is held.
// Assumes load_i and inc_i may both be high, in which case load wins.
module dma_arb_run_cnt
    import dma_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [RCODE_W-1:0] code_i,
    input  logic               inc_i,
    output logic               last_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;

    // Clear the count and latch the limit on a grant; otherwise count transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= run_last_count(code_i);
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The transfer completing now is the last of the run.
    assign last_o = (cnt_q == lim_q);

    // R5: the count never passes the latched limit.
    p_cnt_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);

    // R8: the cycle after a load always starts from zero.
    p_cnt_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == '0));

endmodule

// File: rtl/dma_prio_arb.sv
// DMA channel priority arbiter top. It holds the current owner and re-decides
// when there is no owner, when the owner loses eligibility, or when the
// owner's 2^R-transfer run completes.
// Assumes xfer_done_i is high for one cycle per completed transfer.
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH-1:0]         req_i,
    input  logic [N_CH-1:0]         en_i,
    input  logic [N_CH-1:0]         hi_pri_i,
    input  logic [N_CH*RCODE_W-1:0] run_code_i,
    input  logic                    xfer_done_i,
    output logic [N_CH-1:0]         grant_o,
    output logic [IDX_W-1:0]        grant_idx_o,
    output logic                    rearb_o
);

    logic [N_CH-1:0]    elig;
    logic [RCODE_W-1:0] code_arr [N_CH];
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic               run_last;
    logic               need_arb;
    logic               own_v;
    logic [IDX_W-1:0]   own_idx;
    logic               rearb_q;

    assign elig = req_i & en_i;

    for (genvar k = 0; k < N_CH; k++) begin : g_code
        assign code_arr[k] = run_code_i[k*RCODE_W +: RCODE_W];
    end

    dma_arb_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_pick (
        .elig_i  (elig),
        .hi_i    (hi_pri_i),
        .found_o (pick_found),
        .win_o   (pick_idx)
    );

    // A decision is due when idle, when the owner is released, or when the run ends.
    assign need_arb = !own_v || !elig[own_idx] || (xfer_done_i && run_last);

    dma_arb_run_cnt u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (need_arb),
        .code_i (code_arr[pick_idx]),
        .inc_i  (xfer_done_i && own_v),
        .last_o (run_last)
    );

    // Owner register: loaded only at a rearbitration point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_v   <= 1'b0;
            own_idx <= '0;
            rearb_q <= 1'b0;
        end else if (need_arb) begin
            own_v   <= pick_found;
            own_idx <= pick_found ? pick_idx : '0;
            rearb_q <= pick_found;
        end else begin
            rearb_q <= 1'b0;
        end
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_gnt
        assign grant_o[k] = own_v && (own_idx == IDX_W'(k));
    end
    assign grant_idx_o = own_idx;
    assign rearb_o     = rearb_q;

    // R10: at most one grant bit is set.
    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2: a held grant was eligible in the preceding cycle.
    p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> (|($past(req_i & en_i) & grant_o)));

    // R3: an urgent candidate in the deciding cycle means an urgent winner.
    p_urgent_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb_o && (|$past(req_i & en_i & hi_pri_i))) |-> (|(grant_o & $past(hi_pri_i))));

    // R9: without a rearbitration strobe, a held grant stays put.
    p_hold_midrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearb_o && (|grant_o)) |-> $stable(grant_o));

    // R7: no eligible channel in a cycle gives no grant after it.
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|$past(req_i & en_i)) |-> (grant_o == '0));

endmodule

// File: tb/tb_dma_prio_arb.sv
module tb_dma_prio_arb;

    localparam int N  = 8;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [N-1:0]   en = '0;
    logic [N-1:0]   hi = '0;
    logic [N*4-1:0] rc = '0;
    logic           done = 1'b0;
    logic [N-1:0]   grant_o;
    logic [IW-1:0]  grant_idx_o;
    logic           rearb_o;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string tag = "R1";

    always #10 clk = ~clk;  // 50 MHz

    dma_prio_arb #(.N_CH(N)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .en_i        (en),
        .hi_pri_i    (hi),
        .run_code_i  (rc),
        .xfer_done_i (done),
        .grant_o     (grant_o),
        .grant_idx_o (grant_idx_o),
        .rearb_o     (rearb_o)
    );

    // Behavioural reference: owner number, transfers done, run length.
    int ref_own = -1;
    int ref_cnt = 0;
    int ref_len = 1;
    bit ref_rb  = 1'b0;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ref_own = -1;
            ref_cnt = 0;
            ref_rb  = 1'b0;
        end else begin
            bit need;
            need = (ref_own < 0) || !(req[ref_own] && en[ref_own]) ||
                   (done && (ref_cnt == ref_len - 1));
            if (need) begin
                int w;
                w = -1;
                for (int i = 0; i < N; i++)
                    if (w < 0 && req[i] && en[i] && hi[i]) w = i;
                for (int i = 0; i < N; i++)
                    if (w < 0 && req[i] && en[i]) w = i;
                ref_own = w;
                ref_cnt = 0;
                ref_rb  = (w >= 0);
                if (w >= 0) begin
                    int r;
                    r = int'(rc[w*4 +: 4]);
                    if (r > 10) r = 10;
                    ref_len = 1 << r;
                end
            end else begin
                ref_rb = 1'b0;
                if (done) ref_cnt++;
            end
        end
        #5;
        begin
            logic [N-1:0]  eg;
            logic [IW-1:0] ei;
            eg = (ref_own >= 0) ? (N'(1) << ref_own) : '0;
            ei = (ref_own >= 0) ? IW'(ref_own) : '0;
            n_chk++;
            if (grant_o !== eg || grant_idx_o !== ei || rearb_o !== ref_rb) begin
                n_fail++;
                $display("FAIL %s (R9/R10 model) cycle %0d: grant=%b idx=%0d rearb=%b expected grant=%b idx=%0d rearb=%b",
                         tag, cyc, grant_o, grant_idx_o, rearb_o, eg, ei, ref_rb);
            end
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired, actual cycle %0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic set_rc(input int ch, input int v);
        rc[ch*4 +: 4] = 4'(v);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic dones(input int n);
        done = 1'b1;
        cycles(n);
        done = 1'b0;
    endtask

    // Checks the registered grant just after the coming clock edge.
    task automatic expect_idx(input string t, input int exp_idx);
        @(posedge clk);
        #6;
        n_chk++;
        if (exp_idx < 0) begin
            if (grant_o !== '0) begin
                n_fail++;
                $display("FAIL %s: grant=%b expected none", t, grant_o);
            end
        end else if (grant_o !== (N'(1) << exp_idx)) begin
            n_fail++;
            $display("FAIL %s: grant=%b expected channel %0d", t, grant_o, exp_idx);
        end
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        tag = "R1";
        req = '1;
        en = '1;
        cycles(3);
        expect_idx("R1 reset", -1);
        req = '0;
        rst_n = 1'b1;
        cycles(2);

        // R7: idle, done strobes ignored.
        tag = "R7";
        dones(3);
        expect_idx("R7 idle", -1);

        // R4: lower index wins within the normal group.
        tag = "R4";
        req = 8'b0110_0100;
        expect_idx("R4 lowest", 2);
        req = '0;
        cycles(2);

        // R3: urgent beats a lower index.
        tag = "R3";
        hi = 8'b0010_0000;
        req = 8'b0010_0011;
        expect_idx("R3 urgent", 5);
        req = '0;
        hi = '0;
        cycles(2);

        // R2: a disabled requester is skipped; disabling the owner releases it.
        tag = "R2";
        en = 8'b1111_1110;
        req = 8'b0000_1001;
        expect_idx("R2 skip disabled", 3);
        en = 8'b1111_0110;
        expect_idx("R2 owner disabled", -1);
        en = '1;
        req = '0;
        cycles(2);

        // R5: run of 8 with a lower-index competitor arriving mid-run.
        tag = "R5";
        set_rc(2, 3);
        req = 8'b0000_0100;
        cycles(2);
        req = 8'b0000_0101;
        dones(7);
        expect_idx("R5 held after 7 of 8", 2);
        dones(1);
        expect_idx("R5 released after 8", 0);
        req = '0;
        cycles(2);

        // R5: code 15 acts as 10, a run of 1024.
        set_rc(4, 15);
        req = 8'b0001_0000;
        cycles(2);
        req = 8'b0001_0010;
        dones(1023);
        expect_idx("R5 clamp held at 1023", 4);
        dones(1);
        expect_idx("R5 clamp released at 1024", 1);
        req = '0;
        cycles(2);

        // R6 and R8: early drop, then a regrant gets a full run.
        tag = "R6";
        set_rc(6, 2);
        req = 8'b0100_0000;
        cycles(2);
        dones(3);
        req = '0;
        expect_idx("R6 drop releases", -1);
        tag = "R8";
        req = 8'b0100_0000;
        cycles(2);
        req = 8'b0100_1000;
        dones(3);
        expect_idx("R8 fresh count held at 3 of 4", 6);
        dones(1);
        expect_idx("R8 released after 4", 3);
        req = '0;
        cycles(2);

        // R9/R10: random traffic checked against the model every clock.
        tag = "R9";
        for (int i = 0; i < N; i++) set_rc(i, i % 3);
        for (int k = 0; k < 4000; k++) begin
            if (k % 8 == 0) begin
                req = N'($urandom);
                en  = N'($urandom) | N'($urandom);
                hi  = N'($urandom) & N'($urandom);
            end
            if (k % 200 == 0) set_rc(int'($urandom % N), int'($urandom % 12));
            done = 1'($urandom);
            @(negedge clk);
        end
        done = 1'b0;
        req = '0;
        cycles(3);
        finish_run();
    end

endmodule